// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Queue

This block keeps instructions in program order between dispatch and retirement. It is a circular queue of slots. Each instruction takes as many adjacent slots as it has micro-ops. A zero-micro-op instruction still takes one slot, and no instruction takes more than the whole ring. When a reservation is accepted, the block returns a token. The token is the ring index of the instruction's first slot. Execution units later present that token to mark the instruction complete.

In every cycle the retire logic starts at the oldest instruction and walks forward. It releases each completed instruction until it meets one that has not executed, or until it reaches the per-cycle retire limit. It reports the IDs of the released instructions in age order. Dispatch logic reads the exported free-slot count to decide whether a new instruction fits. Occupancy is held as that count, so a full ring and an empty ring can never be confused.

Top module: `rq_retire_unit`

## Requirements
- R1: The slot cost of a reservation is 1 when `rsv_uops` is 0, QDEPTH when `rsv_uops` exceeds QDEPTH, and `rsv_uops` otherwise.
- R2: An accepted reservation returns on `rsv_token`, in the same cycle, the current tail index. The entry is stored with its executed flag clear. At the next edge the tail moves forward by the cost modulo QDEPTH, and `free_slots` drops by the cost.
- R3: A reservation whose cost exceeds the current `free_slots` is dropped. The tail does not move and `free_slots` does not drop.
- R4: Retirement starts at the oldest entry and is strictly in order. An executed entry that is younger than an unexecuted one does not retire.
- R5: At most RET_LIMIT entries retire in one cycle. A RET_LIMIT of 0 removes the limit.
- R6: `ret_count` and `ret_ids` report, in the same cycle, the entries that retire at the next edge. The oldest entry is in field 0, with field k at bits [k*ID_W +: ID_W]. At that edge the head moves by each entry's cost, and `free_slots` rises by the sum of those costs.
- R7: `exe_dup` is high in the same cycle whenever `exe_valid` targets a token whose executed flag is already set. Such a mark changes no state.
- R8: After reset, `free_slots` equals QDEPTH, `rsv_token` is 0 and `ret_count` is 0.
- R9: A completely filled ring, with `free_slots` at 0, still retires correctly and then accepts new reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_id | input | ID_W | Instruction ID to store |
| rsv_uops | input | UOP_W | Micro-op count of the instruction |
| rsv_token | output | IDX_W | Token (first slot index) for this reservation |
| exe_valid | input | 1 | Executed mark request |
| exe_token | input | IDX_W | Token being marked executed |
| exe_dup | output | 1 | Mark targets an entry already executed |
| free_slots | output | CNT_W | Number of unoccupied slots |
| ret_count | output | CNT_W | Entries retiring at the next edge |
| ret_ids | output | QDEPTH*ID_W | IDs of retiring entries, oldest in field 0 |

## Verification
A wrong tail pointer shows up at once on `rsv_token` for the next reservation. A wrong free count shows on `free_slots` one edge after the bad update, and it also changes which reservations are dropped. A wrong head pointer, a wrong stored cost or a wrong executed flag shows in the same cycle on `ret_count` or `ret_ids`. The two instances, one limited and one unlimited, are driven with streams that mix costs of 0, in range and above the depth with random and duplicate marks. Every cycle is then compared against an age-ordered list model kept in the bench.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // number of ring slots an instruction occupies
  function automatic int slot_cost(input int uops, input int depth);
    if (uops < 1) return 1;
    if (uops > depth) return depth;
    return uops;
  endfunction

  // advance a ring position by n slots, n never above depth
  function automatic int ring_step(input int pos, input int n, input int depth);
    int s;
    s = pos + n;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/rq_slot_store.sv
module rq_slot_store #(
  parameter int QDEPTH = 8,
  parameter int ID_W   = 8,
  localparam int IDX_W = $clog2(QDEPTH),
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ID_W-1:0]                  wr_id,
  input  logic [CNT_W-1:0]                 wr_ns,
  input  logic                             set_en,
  input  logic [IDX_W-1:0]                 set_idx,
  input  logic [QDEPTH-1:0]                clr,
  output logic [QDEPTH-1:0][ID_W-1:0]      id_q,
  output logic [QDEPTH-1:0][CNT_W-1:0]     ns_q,
  output logic [QDEPTH-1:0]                done_q
);

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    logic hit_wr;
    logic hit_set;
    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(i));
    assign hit_set = set_en && (set_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q[i]   <= '0;
        ns_q[i]   <= '0;
        done_q[i] <= 1'b0;
      end else begin
        if (hit_wr) begin
          id_q[i] <= wr_id;
          ns_q[i] <= wr_ns;
        end
        // a fresh reservation wins over any other flag update
        if (hit_wr)       done_q[i] <= 1'b0;
        else if (clr[i])  done_q[i] <= 1'b0;
        else if (hit_set) done_q[i] <= 1'b1;
      end
    end
  end

  AST_RSV_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !done_q[$past(wr_idx)]); // R2

endmodule

// File: rtl/rq_retire_walk.sv
module rq_retire_walk
  import rq_pkg::*;
#(
  parameter int QDEPTH    = 8,
  parameter int ID_W      = 8,
  parameter int RET_LIMIT = 2,
  localparam int IDX_W = $clog2(QDEPTH),
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic [IDX_W-1:0]                 head,
  input  logic [CNT_W-1:0]                 used,
  input  logic [QDEPTH-1:0]                done,
  input  logic [QDEPTH-1:0][CNT_W-1:0]     ns,
  input  logic [QDEPTH-1:0][ID_W-1:0]      ids,
  output logic [CNT_W-1:0]                 cnt,
  output logic [QDEPTH-1:0][ID_W-1:0]      ret_ids,
  output logic [CNT_W-1:0]                 freed,
  output logic [QDEPTH-1:0]                clr,
  output logic [IDX_W-1:0]                 head_next
);

  always_comb begin
    logic [IDX_W-1:0] p;
    logic             go;
    int               consumed;
    int               n;
    p        = head;
    go       = 1'b1;
    consumed = 0;
    n        = 0;
    ret_ids  = '0;
    clr      = '0;
    for (int k = 0; k < QDEPTH; k++) begin
      go = go && (consumed < int'(used)) && done[p] &&
           ((RET_LIMIT == 0) || (k < RET_LIMIT));
      if (go) begin
        ret_ids[k] = ids[p];
        clr[p]     = 1'b1;
        consumed   = consumed + int'(ns[p]);
        p          = IDX_W'(ring_step(int'(p), int'(ns[p]), QDEPTH));
        n          = n + 1;
      end
    end
    cnt       = CNT_W'(n);
    freed     = CNT_W'(consumed);
    head_next = p;
  end

endmodule

// File: rtl/rq_retire_unit.sv
module rq_retire_unit
  import rq_pkg::*;
#(
  parameter int QDEPTH    = 8,
  parameter int ID_W      = 8,
  parameter int UOP_W     = 4,
  parameter int RET_LIMIT = 2,
  localparam int IDX_W = $clog2(QDEPTH),
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rsv_valid,
  input  logic [ID_W-1:0]          rsv_id,
  input  logic [UOP_W-1:0]         rsv_uops,
  output logic [IDX_W-1:0]         rsv_token,
  input  logic                     exe_valid,
  input  logic [IDX_W-1:0]         exe_token,
  output logic                     exe_dup,
  output logic [CNT_W-1:0]         free_slots,
  output logic [CNT_W-1:0]         ret_count,
  output logic [QDEPTH*ID_W-1:0]   ret_ids
);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] free_q;

  // internal events, named for the checks below
  logic [CNT_W-1:0] rsv_cost;
  logic             rsv_take;
  logic [CNT_W-1:0] rsv_dec;
  logic             exe_set;
  logic [CNT_W-1:0] used;

  logic [QDEPTH-1:0][ID_W-1:0]  id_arr;
  logic [QDEPTH-1:0][CNT_W-1:0] ns_arr;
  logic [QDEPTH-1:0]            done_arr;

  logic [CNT_W-1:0]             wk_cnt;
  logic [QDEPTH-1:0][ID_W-1:0]  wk_ids;
  logic [CNT_W-1:0]             wk_freed;
  logic [QDEPTH-1:0]            wk_clr;
  logic [IDX_W-1:0]             wk_head;

  assign rsv_cost = CNT_W'(slot_cost(int'(rsv_uops), QDEPTH));
  assign rsv_take = rsv_valid && (rsv_cost <= free_q);
  assign rsv_dec  = rsv_take ? rsv_cost : '0;
  assign exe_dup  = exe_valid && done_arr[exe_token];
  assign exe_set  = exe_valid && !exe_dup;
  assign used     = CNT_W'(QDEPTH) - free_q;

  rq_slot_store #(.QDEPTH(QDEPTH), .ID_W(ID_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rsv_take),
    .wr_idx  (tail_q),
    .wr_id   (rsv_id),
    .wr_ns   (rsv_cost),
    .set_en  (exe_set),
    .set_idx (exe_token),
    .clr     (wk_clr),
    .id_q    (id_arr),
    .ns_q    (ns_arr),
    .done_q  (done_arr)
  );

  rq_retire_walk #(.QDEPTH(QDEPTH), .ID_W(ID_W), .RET_LIMIT(RET_LIMIT)) u_walk (
    .head      (head_q),
    .used      (used),
    .done      (done_arr),
    .ns        (ns_arr),
    .ids       (id_arr),
    .cnt       (wk_cnt),
    .ret_ids   (wk_ids),
    .freed     (wk_freed),
    .clr       (wk_clr),
    .head_next (wk_head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(QDEPTH);
    end else begin
      head_q <= wk_head;
      if (rsv_take)
        tail_q <= IDX_W'(ring_step(int'(tail_q), int'(rsv_cost), QDEPTH));
      free_q <= free_q - rsv_dec + wk_freed;
    end
  end

  assign rsv_token  = tail_q;
  assign free_slots = free_q;
  assign ret_count  = wk_cnt;
  assign ret_ids    = wk_ids;

  AST_RING_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(head_q) + QDEPTH - int'(free_q)) % QDEPTH) == int'(tail_q)); // R2
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CNT_W'(QDEPTH)); // R9
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_count == '0) |=> $stable(head_q)); // R6
  AST_RET_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_count != '0) |-> done_arr[head_q]); // R4
  AST_RET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (RET_LIMIT == 0) || (int'(ret_count) <= RET_LIMIT)); // R5
  AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && !rsv_take) |=> $stable(tail_q)); // R3
  AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsv_take && exe_valid && (exe_token == tail_q))); // R7

endmodule

// File: tb/tb_rq_retire_unit.sv
module tb_rq_retire_unit;
  localparam int PERIOD = 10;
  localparam int QD = 8;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic       rv [2];
  logic [7:0] rid[2];
  logic [3:0] ru [2];
  logic       ev [2];
  logic [2:0] et [2];
  logic [2:0] tok[2];
  logic       dup[2];
  logic [3:0] fr [2];
  logic [3:0] rc [2];
  logic [63:0] rids[2];

  rq_retire_unit #(.QDEPTH(QD), .ID_W(IW), .UOP_W(4), .RET_LIMIT(2)) dut (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rv[0]), .rsv_id(rid[0]), .rsv_uops(ru[0]),
    .rsv_token(tok[0]), .exe_valid(ev[0]), .exe_token(et[0]), .exe_dup(dup[0]),
    .free_slots(fr[0]), .ret_count(rc[0]), .ret_ids(rids[0]));

  rq_retire_unit #(.QDEPTH(QD), .ID_W(IW), .UOP_W(4), .RET_LIMIT(0)) dut_nl (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rv[1]), .rsv_id(rid[1]), .rsv_uops(ru[1]),
    .rsv_token(tok[1]), .exe_valid(ev[1]), .exe_token(et[1]), .exe_dup(dup[1]),
    .free_slots(fr[1]), .ret_count(rc[1]), .ret_ids(rids[1]));

  int total = 0;
  int bad = 0;

  // age-ordered list model, entry 0 is the oldest
  int m_id  [2][QD];
  int m_cost[2][QD];
  int m_tok [2][QD];
  bit m_done[2][QD];
  int m_n[2], m_tail[2], m_free[2];
  int exp_r[2], exe_j[2];
  int id_ctr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cost_of(input int u);
    return (u == 0) ? 1 : ((u > QD) ? QD : u);
  endfunction

  function automatic int lim_of(input int m);
    return (m == 0) ? 2 : 0;
  endfunction

  task automatic drive(input int m, input bit v, input int u, input bit e, input int j);
    rv[m]  = v;
    ru[m]  = 4'(u);
    rid[m] = 8'(id_ctr);
    id_ctr++;
    exe_j[m] = -1;
    ev[m] = 1'b0;
    et[m] = '0;
    if (e && j >= 0 && j < m_n[m]) begin
      ev[m] = 1'b1;
      et[m] = 3'(m_tok[m][j]);
      exe_j[m] = j;
    end
  endtask

  task automatic check_now(input int m);
    int r;
    bit edup;
    r = 0;
    while (r < m_n[m] && m_done[m][r] && (lim_of(m) == 0 || r < lim_of(m))) r++;
    exp_r[m] = r;
    chk(tok[m] == 3'(m_tail[m]), "R2 token", int'(tok[m]), m_tail[m]);
    chk(fr[m] == 4'(m_free[m]), "R1 R3 R9 free_slots", int'(fr[m]), m_free[m]);
    chk(rc[m] == 4'(r), "R4 R5 ret_count", int'(rc[m]), r);
    for (int k = 0; k < r; k++)
      chk(rids[m][k*IW +: IW] == 8'(m_id[m][k]), "R6 ret_ids",
          int'(rids[m][k*IW +: IW]), m_id[m][k]);
    edup = (exe_j[m] >= 0) && m_done[m][exe_j[m]];
    chk(dup[m] == edup, "R7 exe_dup", int'(dup[m]), int'(edup));
  endtask

  task automatic update(input int m);
    int r, freed, c, oldfree;
    r = exp_r[m];
    oldfree = m_free[m];
    if (exe_j[m] >= 0 && !m_done[m][exe_j[m]]) m_done[m][exe_j[m]] = 1'b1;
    freed = 0;
    for (int k = 0; k < r; k++) freed += m_cost[m][k];
    for (int k = 0; k < QD; k++) begin
      if (k + r < m_n[m]) begin
        m_id[m][k] = m_id[m][k+r];
        m_cost[m][k] = m_cost[m][k+r];
        m_tok[m][k] = m_tok[m][k+r];
        m_done[m][k] = m_done[m][k+r];
      end
    end
    m_n[m] -= r;
    m_free[m] = oldfree + freed;
    c = cost_of(int'(ru[m]));
    if (rv[m] && c <= oldfree) begin
      m_id[m][m_n[m]] = int'(rid[m]);
      m_cost[m][m_n[m]] = c;
      m_tok[m][m_n[m]] = m_tail[m];
      m_done[m][m_n[m]] = 1'b0;
      m_n[m]++;
      m_tail[m] = (m_tail[m] + c) % QD;
      m_free[m] -= c;
    end
  endtask

  task automatic cycle_end();
    #1;
    check_now(0);
    check_now(1);
    @(posedge clk);
    update(0);
    update(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_n[m] = 0; m_tail[m] = 0; m_free[m] = QD; exe_j[m] = -1;
      rv[m] = 0; ru[m] = 0; rid[m] = 0; ev[m] = 0; et[m] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int m = 0; m < 2; m++) begin
      chk(fr[m] == 4'd8, "R8 reset free", int'(fr[m]), 8);
      chk(tok[m] == 3'd0, "R8 reset token", int'(tok[m]), 0);
      chk(rc[m] == 4'd0, "R8 reset ret_count", int'(rc[m]), 0);
    end
    // directed: zero cost, oversize, fill to full, out-of-order marks
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        case (s)
          0: drive(m, 1, 0, 0, -1);   // R1 zero uops take one slot
          1: drive(m, 1, 12, 0, -1);  // R1 R3 clamps to 8, exceeds 7 free
          2: drive(m, 1, 7, 0, -1);   // R9 ring becomes full
          3: drive(m, 1, 1, 1, 1);    // R3 dropped when full, R4 young marked
          4: drive(m, 0, 0, 0, -1);   // R4 nothing retires yet
          5: drive(m, 1, 3, 1, 0);    // R9 full ring, oldest marked
          6: drive(m, 1, 3, 1, 0);    // R7 duplicate mark while retiring
          7: drive(m, 1, 2, 0, -1);
          8: drive(m, 1, 1, 1, 0);
          9: drive(m, 1, 1, 1, 1);
          10: drive(m, 1, 0, 1, 2);
          default: drive(m, 0, 0, 1, 0);
        endcase
      end
      cycle_end();
    end
    // random sweep, costs 0..10 cover below, at and above the depth
    for (int s = 0; s < 4000; s++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++)
        drive(m, ($urandom % 4) != 0, int'($urandom % 11), ($urandom % 3) != 0,
              (m_n[m] > 0) ? int'($urandom % m_n[m]) : -1);
      cycle_end();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule